// File: doc/BRIEF.md
# Single-Pin External Interrupt Request Channel

This block turns one asynchronous, active-low external interrupt pin into a request for the processor. The pin first goes through a two-flop synchronizer. A falling edge on the synchronized signal sets a request latch. Software can also choose a level mode, in which a low pin sets the latch as well.

The latch is cleared in either of two ways:
- the processor pulses a vector-fetch acknowledge input when it services the interrupt;
- software writes a 1 to a write-only acknowledge bit.

A mask bit gates only the request output. A pending event therefore stays latched while it is masked, and it appears as soon as the mask is removed. The block also presents a fixed vector address for its handler.

Software reaches the block through one 8-bit control register. The register has no address; a write strobe selects it. Bit 0 picks the trigger mode, bit 1 is the mask, and bit 2 is the acknowledge. Every other bit reads as 0.

Top module: `extint_channel`

## Requirements
- R1: A falling edge on `pin_n` that is applied between clock edges shows up on `irq_req` after the third rising clock edge that follows it (two synchronizer flops, then the latch), provided the mask is 0.
- R2: With the trigger mode bit (bit 0) at 0, only falling edges set the latch. If the pin is held low after the latch has been cleared, the latch is not set again.
- R3: With the trigger mode bit at 1, a low synchronized pin sets the latch on every clock. An acknowledge that arrives while the pin is still low leaves the request asserted.
- R4: While the mask bit (bit 1) is 1, `irq_req` is 0, but the latch keeps its state. Clearing the mask shows a pending request on the next cycle.
- R5: A write with bit 2 of `reg_wdata` at 1 clears the latch at that clock edge.
- R6: A high `vec_ack` clears the latch at that clock edge.
- R7: If a set condition and a clear (from either source) happen in the same cycle, the set wins and the latch is 1 afterwards.
- R8: `reg_rdata` is {5'b0, 1'b0, mask, mode}. Bit 2 always reads 0. A write updates the mode and mask bits at that edge.
- R9: `vec_addr` is always 16'hFFFA, the low byte of the handler vector pair 0xFFFA/0xFFFB.
- R10: After reset, the mode bit, the mask bit and the latch are all 0, so `irq_req` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data: bit 2 ack, bit 1 mask, bit 0 mode |
| reg_rdata | output | 8 | Control register read data |
| vec_ack | input | 1 | Vector-fetch acknowledge from the CPU |
| irq_req | output | 1 | Masked interrupt request |
| vec_addr | output | 16 | Handler vector address |

## Verification
The bench targets the following corner cases:
- **Acknowledge against a new event in the same cycle.** A design that let the clear win would lose that event.
- **A pin held low after an acknowledge.** In edge mode the latch must stay clear; a design that confused edge and level would assert again. In level mode the latch must stay set; a design that ignored the level would drop it.
- **Unmasking while a request is pending.** A design that masked the latch itself, rather than the output, would forget the event.
- **Latency from the pin to the request.** An off-by-one in the synchronizer or the edge history shows up as the request appearing one cycle early or late.

A cycle-level model in the bench is compared against the outputs after every step, under both directed sequences and seeded random stimulus.

// File: rtl/extint_pkg.sv
// Shared constants for the external interrupt channel.
// Assumes: the register layout below is fixed by software.
package extint_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_MODE   = 0;
    localparam int BIT_MASK   = 1;
    localparam int BIT_ACK    = 2;
    localparam int VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_DEFAULT = 16'hFFFA;
endpackage

// File: rtl/extint_sync.sv
// Multi-flop synchronizer for an asynchronous level.
// Assumes: the input idles at logic 1 (active-low pin), so reset loads 1s
// to avoid a false edge after reset.
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
// Falling-edge / low-level detector and request latch.
// Assumes: pin_s is already synchronized; the set condition has priority
// over any clear in the same cycle.
module extint_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic level_mode,
    input  logic clr_i,
    output logic latch_o
);
    logic prev_s;
    logic fall;
    logic set;

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_s <= 1'b1;
        else        prev_s <= pin_s;
    end

    assign fall = prev_s & ~pin_s;
    assign set  = fall | (level_mode & ~pin_s);

    // Request latch: set wins, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_o <= 1'b0;
        else if (set)   latch_o <= 1'b1;
        else if (clr_i) latch_o <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> latch_o);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set) |=> !latch_o);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_o && !set) |=> !latch_o);
endmodule

// File: rtl/extint_regs.sv
// Control register: trigger mode and mask bits, plus a write-only acknowledge.
// Assumes: a single register selected by the write strobe alone.
module extint_regs
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             mode_o,
    output logic             mask_o,
    output logic             ack_wr_o,
    output logic [REG_W-1:0] rdata_o
);
    // Store the mode and mask bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= 1'b0;
            mask_o <= 1'b0;
        end else if (wr_i) begin
            mode_o <= wdata_i[BIT_MODE];
            mask_o <= wdata_i[BIT_MASK];
        end
    end

    // The acknowledge is a one-cycle pulse taken from the write.
    assign ack_wr_o = wr_i & wdata_i[BIT_ACK];

    // Read back: the acknowledge bit and the unused bits read as 0.
    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_MODE] = mode_o;
        rdata_o[BIT_MASK] = mask_o;
    end

    assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mode_o == $past(wdata_i[BIT_MODE])) && (mask_o == $past(wdata_i[BIT_MASK])));
endmodule

// File: rtl/extint_channel.sv
// Top of the single-pin external interrupt channel: synchronizer, detector
// and latch, and control register; drives a masked request and a vector.
// Assumes: pin_n is asynchronous and active low; vec_ack is a one-cycle
// strobe in the clk domain.
module extint_channel
    import extint_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [VEC_W-1:0] VEC_ADDR    = VEC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             vec_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec_addr
);
    logic pin_s;
    logic mode;
    logic mask;
    logic ack_wr;
    logic latch;

    extint_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(pin_n), .sync_o(pin_s)
    );

    extint_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .wdata_i(reg_wdata),
        .mode_o(mode), .mask_o(mask), .ack_wr_o(ack_wr), .rdata_o(reg_rdata)
    );

    extint_detect det_i (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .level_mode(mode),
        .clr_i(ack_wr | vec_ack), .latch_o(latch)
    );

    // The mask gates only the output, so the latch keeps pending events.
    assign irq_req  = latch & ~mask;
    assign vec_addr = VEC_ADDR;

    assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_req);
    assert_vec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && pin_s && !mode && !$past(pin_s == 1'b0)) |=> !irq_req);
endmodule

// File: tb/extint_channel_tb_top.sv
module extint_channel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       vec_ack = 1'b0;
    logic       irq_req;
    logic [15:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state (one cycle behind the next edge).
    bit m_s1 = 1, m_s2 = 1, m_prev = 1, m_lat = 0, m_mode = 0, m_mask = 0;

    always #2.5 clk = ~clk;

    extint_channel dut_i (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
        .irq_req(irq_req), .vec_addr(vec_addr)
    );

    function automatic bit exp_irq();
        return m_lat & ~m_mask;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {5'b0, 1'b0, m_mask, m_mode};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs (at a negedge), advance the model, compare.
    task automatic step(input bit p, input bit w, input logic [7:0] wd, input bit a, input string tag);
        bit fall, set, clr;
        pin_n = p; reg_wr = w; reg_wdata = wd; vec_ack = a;
        fall = m_prev & ~m_s2;
        set  = fall | (m_mode & ~m_s2);
        clr  = (w & wd[2]) | a;
        @(negedge clk);
        m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
        if (set) m_lat = 1; else if (clr) m_lat = 0;
        if (w) begin m_mode = wd[0]; m_mask = wd[1]; end
        chk({tag, " irq"}, {15'b0, irq_req}, {15'b0, exp_irq()});
        chk({tag, " rdata"}, {8'b0, reg_rdata}, {8'b0, exp_rd()});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 irq", {15'b0, irq_req}, 16'h0);
        chk("R10 rdata", {8'b0, reg_rdata}, 16'h0);
        // R9: vector address
        chk("R9 vec", vec_addr, 16'hFFFA);

        // R1: falling edge latency of three edges
        step(0, 0, 0, 0, "R1");
        chk("R1 early", {15'b0, irq_req}, 16'h0);
        step(0, 0, 0, 0, "R1");
        chk("R1 early2", {15'b0, irq_req}, 16'h0);
        step(0, 0, 0, 0, "R1");
        chk("R1 rise", {15'b0, irq_req}, 16'h1);
        // R5: software acknowledge; R2: pin still low, edge mode stays clear
        step(0, 1, 8'h04, 0, "R5");
        chk("R5 cleared", {15'b0, irq_req}, 16'h0);
        repeat (4) step(0, 0, 0, 0, "R2");
        chk("R2 held low", {15'b0, irq_req}, 16'h0);
        // R3: level mode, pin low, acknowledge does not drop it
        step(0, 1, 8'h01, 0, "R3");
        step(0, 0, 0, 0, "R3");
        chk("R3 level set", {15'b0, irq_req}, 16'h1);
        step(0, 0, 0, 1, "R3");
        chk("R3 ack while low", {15'b0, irq_req}, 16'h1);
        // R6: pin high again, vector ack clears
        step(1, 1, 8'h00, 0, "R6");
        repeat (3) step(1, 0, 0, 0, "R6");
        step(1, 0, 0, 1, "R6");
        chk("R6 vec clear", {15'b0, irq_req}, 16'h0);
        // R4: mask hides a pending event, unmask shows it
        step(1, 1, 8'h02, 0, "R4");
        step(0, 0, 0, 0, "R4");
        repeat (3) step(0, 0, 0, 0, "R4");
        chk("R4 masked", {15'b0, irq_req}, 16'h0);
        step(0, 1, 8'h00, 0, "R4");
        chk("R4 unmasked", {15'b0, irq_req}, 16'h1);
        // R7: edge arrives in the same cycle as an acknowledge
        step(1, 1, 8'h04, 0, "R7");
        repeat (3) step(1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, "R7");
        chk("R7 set wins", {15'b0, irq_req}, 16'h1);
        // R8: ack bit reads 0 after a write of all ones
        step(1, 1, 8'hFF, 0, "R8");
        chk("R8 readback", {8'b0, reg_rdata}, 16'h0003);

        // Seeded random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            bit p, w, a;
            logic [7:0] wd;
            p  = ($urandom % 6 == 0) ? ~pin_n : pin_n;
            w  = ($urandom % 8 == 0);
            wd = 8'($urandom);
            a  = ($urandom % 16 == 0);
            step(p, w, wd, a, "R4 R8 random");
        end
        chk("R9 vec end", vec_addr, 16'hFFFA);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule